// File: doc/BRIEF.md
# Reprogrammable Logic Cell

This block is one tile of a programmable logic fabric. It holds two independent 4-input function generators, each a writable 16-entry, 1-bit table. One is called F and the other G. A third stage, H, passes the F result or the G result depending on the dedicated cell input `h1`. Four routing selects decide what reaches each of four outputs:

- the combinational outputs `x` and `y`;
- the data inputs of two flip-flops, which drive the registered outputs `xq` and `yq`.

All 36 configuration bits are loaded serially through a shift port while `cfg_en` is high. The bits are ordered as follows:

1. F table entries 0 to 15.
2. G table entries 0 to 15.
3. The select for `x`, then `y`, then `xq`, then `yq`.

While loading, the flip-flops hold their state, and the combinational outputs carry no meaning until loading ends. A synchronous active-high reset clears both flip-flops and the whole configuration.

Top module: `clb_cell`

## Requirements
- R1: In the cycle after a synchronous reset, `xq`, `yq`, `x` and `y` are all 0, because the configuration is cleared to all zeros.
- R2: With loading finished, the F result equals F table entry `f_in`. Entry i is the (i+1)-th bit shifted in.
- R3: With loading finished, the G result equals G table entry `g_in`. Entry i is the (i+17)-th bit shifted in.
- R4: The H result is the F result when `h1` is 0 and the G result when `h1` is 1.
- R5: The X select is the 33rd bit shifted in. Output `x` shows F when this bit is 0 and H when it is 1.
- R6: The Y select is the 34th bit shifted in. Output `y` shows G when this bit is 0 and H when it is 1.
- R7: The XQ select is the 35th bit shifted in. On a rising edge with `ce` high and `cfg_en` low, `xq` captures F when this bit is 0 and H when it is 1.
- R8: The YQ select is the 36th bit shifted in. On such an edge, `yq` captures G when this bit is 0 and H when it is 1.
- R9: When `ce` is low, or `cfg_en` is high, `xq` and `yq` keep their values across the edge.
- R10: Each rising edge with `cfg_en` high shifts in one bit from `cfg_din`. After 36 such edges, the earlier configuration is fully replaced. With `cfg_en` low, the configuration does not change.
- R11: Reset clears `xq` and `yq` even when `ce` is high and the flip-flop data inputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous active-high reset of flip-flops and configuration |
| cfg_en | input | 1 | Configuration shift enable; also freezes the flip-flops |
| cfg_din | input | 1 | Serial configuration data |
| ce | input | 1 | Flip-flop clock enable, active high |
| f_in | input | 4 | Address of the F table |
| g_in | input | 4 | Address of the G table |
| h1 | input | 1 | H stage select: 0 picks F, 1 picks G |
| x | output | 1 | Combinational output, F or H |
| y | output | 1 | Combinational output, G or H |
| xq | output | 1 | Registered output, F or H |
| yq | output | 1 | Registered output, G or H |

## Verification
Every configuration is exercised with a full sweep of all 16 addresses on both tables, and `h1` toggles along the way.

The table contents are chosen so that they distinguish their own entries:

- A one-hot F table (only entry 15 set) separates correct entry ordering from reversed ordering.
- A lopsided G pattern separates G from F when the H stage or an output select picks the wrong source.

Select words of all zeros, all ones and a mixed 0101 show that each of the four routing bits acts alone and in its own position. Runs with `ce` low, with loading active and with reset asserted while `ce` is high separate holding from capturing. A second load over an earlier one shows that no stale bits remain.

// File: rtl/clb_pkg.sv
package clb_pkg;
  // Number of routing select bits stored after the two tables
  localparam int unsigned NUM_SEL = 4;

  // Position of each routing select inside the select field
  localparam int unsigned SEL_X  = 0;
  localparam int unsigned SEL_Y  = 1;
  localparam int unsigned SEL_XQ = 2;
  localparam int unsigned SEL_YQ = 3;

  typedef struct packed {
    logic yq_h;  // 1: yq captures H, 0: captures G
    logic xq_h;  // 1: xq captures H, 0: captures F
    logic y_h;   // 1: y shows H, 0: shows G
    logic x_h;   // 1: x shows H, 0: shows F
  } route_sel_t;
endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  // First bit shifted in ends up at index 0 after W shifts
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (shift_en) begin
      word <= {din, word[W-1:1]};
    end
  end
endmodule

// File: rtl/clb_lut.sv
module clb_lut #(
  parameter int unsigned K = 4,
  localparam int unsigned DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [K-1:0]     addr,
  output logic             dout
);
  always_comb begin
    dout = table_bits[addr];
  end
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage
  import clb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ce,
  input  logic       cfg_en,
  input  logic       f_res,
  input  logic       g_res,
  input  logic       h1,
  input  route_sel_t sel,
  output logic       h_res,
  output logic       x,
  output logic       y,
  output logic       xq,
  output logic       yq
);
  logic d_x;
  logic d_y;
  logic ff_en;

  always_comb begin
    h_res = h1 ? g_res : f_res;
    x     = sel.x_h  ? h_res : f_res;
    y     = sel.y_h  ? h_res : g_res;
    d_x   = sel.xq_h ? h_res : f_res;
    d_y   = sel.yq_h ? h_res : g_res;
    ff_en = ce & ~cfg_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xq <= 1'b0;
      yq <= 1'b0;
    end else if (ff_en) begin
      xq <= d_x;
      yq <= d_y;
    end
  end
endmodule

// File: rtl/clb_cell.sv
module clb_cell
  import clb_pkg::*;
#(
  parameter int unsigned LUT_K = 4,
  localparam int unsigned DEPTH = 1 << LUT_K,
  localparam int unsigned CFG_W = 2 * DEPTH + NUM_SEL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic             ce,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             h1,
  output logic             x,
  output logic             y,
  output logic             xq,
  output logic             yq
);
  logic [CFG_W-1:0] cfg_word;
  logic [DEPTH-1:0] tab   [2];
  logic [LUT_K-1:0] addr  [2];
  logic             res   [2];
  logic             f_res;
  logic             g_res;
  logic             h_res;
  route_sel_t       sel;

  clb_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .word     (cfg_word)
  );

  assign addr[0] = f_in;
  assign addr[1] = g_in;
  assign sel     = route_sel_t'(cfg_word[CFG_W-1 -: NUM_SEL]);

  // Table 0 is F (loaded first), table 1 is G
  for (genvar t = 0; t < 2; t++) begin : g_fgen
    assign tab[t] = cfg_word[t*DEPTH +: DEPTH];
    clb_lut #(.K(LUT_K)) u_lut (
      .table_bits (tab[t]),
      .addr       (addr[t]),
      .dout       (res[t])
    );
  end

  assign f_res = res[0];
  assign g_res = res[1];

  clb_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .cfg_en (cfg_en),
    .f_res  (f_res),
    .g_res  (g_res),
    .h1     (h1),
    .sel    (sel),
    .h_res  (h_res),
    .x      (x),
    .y      (y),
    .xq     (xq),
    .yq     (yq)
  );
endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk #(
  parameter int unsigned W = 36,
  localparam int unsigned D = (W - 4) / 2
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_en,
  input logic         cfg_din,
  input logic         ce,
  input logic         h1,
  input logic         x,
  input logic         xq,
  input logic         yq,
  input logic [W-1:0] cfg_word,
  input logic         f_res,
  input logic         g_res
);
  // R1 and R11: reset clears both flip-flops
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (xq == 1'b0 && yq == 1'b0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!ce || cfg_en) |=> ($stable(xq) && $stable(yq)));

  assert_shift_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (cfg_word == {$past(cfg_din), $past(cfg_word[W-1:1])}));

  assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_word));

  assert_hsel_f_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && cfg_word[2*D] && !h1) |-> (x == f_res));

  assert_hsel_g_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && cfg_word[2*D] && h1) |-> (x == g_res));

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (ce && !cfg_en) |=> (xq == $past(cfg_word[W-2] ? (h1 ? g_res : f_res) : f_res)));
endmodule

bind clb_cell clb_cell_chk #(.W(CFG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_din  (cfg_din),
  .ce       (ce),
  .h1       (h1),
  .x        (x),
  .xq       (xq),
  .yq       (yq),
  .cfg_word (cfg_word),
  .f_res    (f_res),
  .g_res    (g_res)
);

// File: tb/clb_cell_test.sv
module clb_cell_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic [3:0] exp;   // {x, y, xq, yq}
    logic [3:0] mask;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic       ce = 1'b0;
  logic [3:0] f_in = '0;
  logic [3:0] g_in = '0;
  logic       h1 = 1'b0;
  logic       x, y, xq, yq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  // bench model of the configuration and flip-flops
  logic [15:0] m_f = '0;
  logic [15:0] m_g = '0;
  logic [3:0]  m_sel = '0;
  logic        m_xq = 1'b0;
  logic        m_yq = 1'b0;

  clb_cell uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .ce(ce),
    .f_in(f_in), .g_in(g_in), .h1(h1), .x(x), .y(y), .xq(xq), .yq(yq)
  );

  always #(PERIOD/2) clk = ~clk;

  // monitor: compare one item per edge, shortly after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it  = sb.pop_front();
        act = {x, y, xq, yq};
        checks++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: {x,y,xq,yq} actual %b expected %b (mask %b)",
                   it.tag, act, it.exp, it.mask);
        end
      end
    end
  end

  task automatic do_reset(input string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b1; cfg_en = 1'b0;
    m_f = '0; m_g = '0; m_sel = '0; m_xq = 1'b0; m_yq = 1'b0;
    it.exp = 4'b0000; it.mask = 4'b1111; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic shift_bit(input logic b);
    item_t it;
    @(negedge clk);
    cfg_en = 1'b1; cfg_din = b; ce = 1'b1;
    it.exp = {2'b00, m_xq, m_yq}; it.mask = 4'b0011; it.tag = "R9 load hold";
    sb.push_back(it);
  endtask

  task automatic load(input logic [15:0] tf, input logic [15:0] tg, input logic [3:0] ts);
    for (int i = 0; i < 16; i++) shift_bit(tf[i]);
    for (int i = 0; i < 16; i++) shift_bit(tg[i]);
    for (int i = 0; i < 4; i++)  shift_bit(ts[i]);
    m_f = tf; m_g = tg; m_sel = ts;
  endtask

  task automatic step(input logic [3:0] fa, input logic [3:0] ga,
                      input logic hh, input logic en, input string tag);
    item_t it;
    logic fv, gv, hv, xv, yv;
    @(negedge clk);
    cfg_en = 1'b0; f_in = fa; g_in = ga; h1 = hh; ce = en;
    fv = m_f[fa]; gv = m_g[ga]; hv = hh ? gv : fv;
    xv = m_sel[0] ? hv : fv;
    yv = m_sel[1] ? hv : gv;
    if (en) begin
      m_xq = m_sel[2] ? hv : fv;
      m_yq = m_sel[3] ? hv : gv;
    end
    it.exp = {xv, yv, m_xq, m_yq}; it.mask = 4'b1111; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset("R1 reset");

    // R2 R3: plain tables, all selects 0 (x=F, y=G, xq<=F, yq<=G)
    load(16'h8000, 16'h1E4B, 4'b0000);
    for (int i = 0; i < 16; i++) step(4'(i), 4'(15 - i), 1'(i), 1'b1, "R2 R3 F/G lookup");

    // R10: reload over the previous contents; R4 R5 R6 R7 R8: all selects pick H
    load(16'hFFFE, 16'h00F3, 4'b1111);
    for (int i = 0; i < 16; i++) step(4'(i), 4'(i), 1'b0, 1'b1, "R4 R5 R7 H=F");
    for (int i = 0; i < 16; i++) step(4'(i), 4'(i ^ 5), 1'b1, 1'b1, "R4 R6 R8 H=G");

    // mixed selects: x=H, y=G, xq<=H, yq<=G
    load(16'h6996, 16'hC0A5, 4'b0101);
    for (int i = 0; i < 16; i++) step(4'(i), 4'(3 * i), 1'(i >> 1), 1'b1, "R5 R6 R7 R8 mixed");

    // R9: clock enable low holds flip-flops
    step(4'd1, 4'd0, 1'b1, 1'b1, "R9 prime");
    for (int i = 0; i < 8; i++) step(4'(i * 2), 4'(i), 1'(i), 1'b0, "R9 ce low hold");

    // R11: reset with ce high and data 1
    load(16'hFFFF, 16'hFFFF, 4'b0000);
    step(4'd3, 4'd3, 1'b0, 1'b1, "R11 set ones");
    @(negedge clk);
    ce = 1'b1;
    do_reset("R11 reset with ce high");
    step(4'd7, 4'd7, 1'b0, 1'b1, "R1 R10 cleared config");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule